// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block holds the pending and in-service state for a small vectored interrupt controller. It serves seven sources: three timers, two DMA channels and two external inputs. A one-cycle request pulse from a source latches into a pending bit. A fixed-priority selector picks the highest pending source that is not blocked and raises a request towards the CPU. When the CPU acknowledges, the selected source's pending bit clears and its group is marked in service. All three timers share one in-service group.

Software ends a handler by writing the group's type code to an end-of-interrupt address. While a group is in service, its sources stay pending but are not presented to the CPU. An optional nesting mode lifts that block for the two external inputs only. The request and in-service state can be read through a small register port. Reads are combinational, and writes take effect at the next clock edge.

Top module: `irq_pend_track`

## Requirements
- R1: After reset the request view, the in-service view and the summary view all read 0x0000, and `irq_o` is low.
- R2: A request pulse sets its pending bit at the next edge. In the request view (address 0), timer0 sits at bit 0, DMA0 at bit 2, DMA1 at bit 3, timer1 at bit 4 and timer2 at bit 5. Bits 1 and 15:6 always read zero, and the external inputs do not appear in this view.
- R3: An acknowledge (`ack_i` high while `irq_o` is high) clears the pending bit of the source shown on `irq_src_o` and sets that source's group in service. The in-service view (address 1) has the timer group at bit 0, DMA0 at bit 2, DMA1 at bit 3, ext0 at bit 4 and ext1 at bit 5.
- R4: A write to address 2 whose full 16-bit data equals a group's type code clears that group's in-service bit. The codes are timer group 8, DMA0 10, DMA1 11, ext0 12 and ext1 13. Any other value has no effect.
- R5: A source whose group is in service stays pending but is not presented. `irq_o` is low when only such sources are pending, and the source is presented again once its group is released.
- R6: With `nest_mode_i` high, ext0 and ext1 are presented even while their own group is in service. Timers and DMA stay blocked.
- R7: Priority is timer0 > timer1 > timer2 > DMA0 > DMA1 > ext0 > ext1. `irq_src_o` encodes these sources as 0 to 6, in that order.
- R8: Bit 0 of the summary view (address 3) is the OR of the three timer pending bits. All of its other bits read zero.
- R9: A request pulse in the same cycle as the acknowledge of that same source leaves the source pending.
- R10: An acknowledge and an end-of-interrupt write for the same group in the same cycle leave the in-service bit set.
- R11: Writes to addresses 0, 1 and 3 change no state. Address 2 reads as zero.
- R12: `ack_i` while `irq_o` is low changes neither pending nor in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_req_i | input | 3 | Timer request pulses, bit n is timer n |
| dma_req_i | input | 2 | DMA channel request pulses |
| ext_req_i | input | 2 | External input request pulses |
| nest_mode_i | input | 1 | Lets the external inputs re-interrupt while in service |
| irq_o | output | 1 | A presentable pending source exists |
| irq_src_o | output | 3 | Code of the selected source (0 to 6) |
| ack_i | input | 1 | CPU acknowledge of the selected source |
| reg_addr_i | input | 2 | Register address: 0 request, 1 in-service, 2 end-of-interrupt, 3 summary |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational read data |

## Verification
Two pairs of events can fall in the same cycle and compete for the same bit. The first pair is an acknowledge and a fresh request pulse from the same source, which compete for the pending bit. The second pair is an acknowledge and an end-of-interrupt write for the same group, which compete for the in-service bit. The bench drives each pair within one clock period. For the second pair it enables nesting mode so that an external input already in service can be acknowledged again. It then reads the views back: the pending bit must survive the first collision, and the in-service bit must survive the second. A later lone end-of-interrupt write must still release the group.

// File: rtl/irqtrk_pkg.sv
package irqtrk_pkg;
  localparam int N_TMR  = 3;
  localparam int N_DMA  = 2;
  localparam int N_EXT  = 2;
  localparam int N_SRC  = N_TMR + N_DMA + N_EXT;
  localparam int N_GRP  = 1 + N_DMA + N_EXT;
  localparam int SRC_W  = $clog2(N_SRC);
  localparam int EXT_LO = N_TMR + N_DMA;
  localparam int REG_AW = 2;

  typedef logic [N_SRC-1:0] src_vec_t;
  typedef logic [N_GRP-1:0] grp_vec_t;

  typedef enum logic [REG_AW-1:0] {
    REG_REQ = 2'd0,
    REG_ISR = 2'd1,
    REG_EOI = 2'd2,
    REG_SUM = 2'd3
  } reg_addr_e;

  // source index -> in-service group (all timers share group 0)
  function automatic int src_grp(input int s);
    return (s < N_TMR) ? 0 : s - N_TMR + 1;
  endfunction

  // group -> end-of-interrupt type code
  function automatic logic [7:0] grp_code(input int g);
    return (g == 0) ? 8'd8 : 8'(9 + g);
  endfunction

  // timer/DMA source -> bit in the request view (software visible layout)
  function automatic int req_bit(input int s);
    case (s)
      0:       return 0;
      1:       return 4;
      2:       return 5;
      3:       return 2;
      default: return 3;
    endcase
  endfunction

  // group -> bit in the in-service view
  function automatic int isr_bit(input int g);
    return (g == 0) ? 0 : g + 1;
  endfunction
endpackage

// File: rtl/irqtrk_pending.sv
module irqtrk_pending
  import irqtrk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t req,
  input  src_vec_t clr,
  output src_vec_t pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | req;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    // R9: a fresh pulse always lands, even against a clear
    p_req_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req[i] |=> pend_q[i]);
    // R3: an acknowledged source leaves the pending set
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !req[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/irqtrk_inservice.sv
module irqtrk_inservice
  import irqtrk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  grp_vec_t          set,
  input  logic              eoi_valid,
  input  logic [DATA_W-1:0] eoi_data,
  output grp_vec_t          isr_q
);
  grp_vec_t hit;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign hit[g] = eoi_valid && (eoi_data == DATA_W'(grp_code(g)));

    always_ff @(posedge clk) begin
      if (!rst_n) isr_q[g] <= 1'b0;
      else        isr_q[g] <= set[g] | (isr_q[g] & ~hit[g]);
    end

    // R4: matching end-of-interrupt releases the group
    p_eoi_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && !set[g]) |=> !isr_q[g]);
    // R10: acknowledge wins over a same-cycle release
    p_ack_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> isr_q[g]);
  end
endmodule

// File: rtl/irqtrk_select.sv
module irqtrk_select
  import irqtrk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         pend,
  input  grp_vec_t         isr,
  input  logic             nest,
  output src_vec_t         grant,
  output logic [SRC_W-1:0] grant_idx,
  output logic             any
);
  src_vec_t blocked;
  src_vec_t elig;

  for (genvar s = 0; s < N_SRC; s++) begin : g_blk
    if (s >= EXT_LO) begin : g_ext
      assign blocked[s] = isr[src_grp(s)] && !nest;
    end else begin : g_int
      assign blocked[s] = isr[src_grp(s)];
    end
  end

  assign elig = pend & ~blocked;
  assign any  = |elig;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (elig[s]) begin
        grant     = '0;
        grant[s]  = 1'b1;
        grant_idx = SRC_W'(s);
      end
    end
  end

  // R7: at most one source granted
  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R5: a grant always names a pending source
  p_grant_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0);
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
  import irqtrk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TMR-1:0]  tmr_req_i,
  input  logic [N_DMA-1:0]  dma_req_i,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic              nest_mode_i,
  output logic              irq_o,
  output logic [SRC_W-1:0]  irq_src_o,
  input  logic              ack_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  src_vec_t req_vec, clr_vec, pend_q, grant;
  grp_vec_t set_vec, isr_q;
  logic     ack_fire, eoi_valid;

  assign req_vec  = {ext_req_i, dma_req_i, tmr_req_i};
  assign ack_fire = ack_i && irq_o;
  assign clr_vec  = ack_fire ? grant : '0;
  assign eoi_valid = reg_wr_i && (reg_addr_i == REG_EOI);

  always_comb begin
    set_vec = '0;
    for (int s = 0; s < N_SRC; s++)
      if (clr_vec[s]) set_vec[src_grp(s)] = 1'b1;
  end

  irqtrk_pending u_pend (
    .clk(clk), .rst_n(rst_n), .req(req_vec), .clr(clr_vec), .pend_q(pend_q)
  );

  irqtrk_inservice #(.DATA_W(DATA_W)) u_isr (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .eoi_valid(eoi_valid),
    .eoi_data(reg_wdata_i), .isr_q(isr_q)
  );

  irqtrk_select u_sel (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .isr(isr_q), .nest(nest_mode_i),
    .grant(grant), .grant_idx(irq_src_o), .any(irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_REQ: for (int s = 0; s < EXT_LO; s++) reg_rdata_o[req_bit(s)] = pend_q[s];
      REG_ISR: for (int g = 0; g < N_GRP; g++)  reg_rdata_o[isr_bit(g)] = isr_q[g];
      REG_SUM: reg_rdata_o[0] = |pend_q[N_TMR-1:0];
      default: reg_rdata_o = '0;
    endcase
  end

  // R2: reserved request-view bits never read as one
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == REG_REQ) |-> (reg_rdata_o[DATA_W-1:6] == '0 && !reg_rdata_o[1]));
  // R12: an acknowledge with nothing presented leaves in-service state alone
  p_idle_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eoi_valid) |=> $stable(isr_q));
endmodule

// File: tb/sim_irq_pend_track.sv
module sim_irq_pend_track;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tmr = '0;
  logic [1:0]  dma = '0;
  logic [1:0]  ext = '0;
  logic        nest = 1'b0;
  logic        irq;
  logic [2:0]  src;
  logic        ack = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_pend_track u0 (
    .clk(clk), .rst_n(rst_n), .tmr_req_i(tmr), .dma_req_i(dma), .ext_req_i(ext),
    .nest_mode_i(nest), .irq_o(irq), .irq_src_o(src), .ack_i(ack),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock with the given stimulus, then idle inputs, ends at negedge
  task automatic cyc(input logic [2:0] t, input logic [1:0] d, input logic [1:0] e,
                     input logic a, input logic w, input logic [1:0] wa,
                     input logic [15:0] wd);
    tmr = t; dma = d; ext = e; ack = a; wr = w; addr = wa; wdata = wd;
    @(posedge clk); #1;
    tmr = '0; dma = '0; ext = '0; ack = 1'b0; wr = 1'b0; wdata = '0;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] t, input logic [1:0] d, input logic [1:0] e);
    cyc(t, d, e, 1'b0, 1'b0, 2'd0, 16'h0);
  endtask
  task automatic do_ack();
    cyc('0, '0, '0, 1'b1, 1'b0, 2'd0, 16'h0);
  endtask
  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    cyc('0, '0, '0, 1'b0, 1'b1, a, d);
  endtask
  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic do_reset();
    nest = 1'b0;
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(0, v); chk("R1 request view", v, 0);
    rd(1, v); chk("R1 in-service view", v, 0);
    rd(3, v); chk("R1 summary view", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_req_map();
    logic [15:0] v;
    do_reset();
    pulse(3'b111, 2'b11, 2'b00);
    rd(0, v); chk("R2 bit layout", v, 16'h003D);
    do_reset();
    pulse(3'b010, 2'b00, 2'b11);
    rd(0, v); chk("R2 timer1 only, ext hidden", v, 16'h0010);
    chk("R2 irq", irq, 1);
  endtask

  task automatic t_ack();
    logic [15:0] v;
    do_reset();
    pulse(3'b000, 2'b01, 2'b00);
    chk("R3 src dma0", src, 3);
    do_ack();
    rd(0, v); chk("R3 pending cleared", v, 0);
    rd(1, v); chk("R3 in-service dma0", v, 16'h0004);
    chk("R3 irq low", irq, 0);
  endtask

  task automatic t_eoi();
    logic [15:0] v;
    do_reset();
    pulse(3'b000, 2'b10, 2'b00);
    do_ack();
    rd(1, v); chk("R4 dma1 in service", v, 16'h0008);
    wr_reg(2, 16'd10);
    rd(1, v); chk("R4 wrong code", v, 16'h0008);
    wr_reg(2, 16'h010B);
    rd(1, v); chk("R4 upper bits mismatch", v, 16'h0008);
    wr_reg(2, 16'd11);
    rd(1, v); chk("R4 dma1 released", v, 0);
    pulse(3'b010, 2'b00, 2'b00);
    do_ack();
    rd(1, v); chk("R4 timer group set", v, 16'h0001);
    wr_reg(2, 16'd8);
    rd(1, v); chk("R4 timer group released", v, 0);
  endtask

  task automatic t_block();
    logic [15:0] v;
    do_reset();
    pulse(3'b001, 2'b00, 2'b00);
    do_ack();
    pulse(3'b100, 2'b00, 2'b00);
    rd(0, v); chk("R5 blocked still pending", v, 16'h0020);
    chk("R5 irq low while blocked", irq, 0);
    wr_reg(2, 16'd8);
    chk("R5 irq after release", irq, 1);
    chk("R5 src timer2", src, 2);
  endtask

  task automatic t_nest();
    logic [15:0] v;
    do_reset();
    nest = 1'b1;
    pulse(3'b000, 2'b00, 2'b01);
    do_ack();
    rd(1, v); chk("R6 ext0 in service", v, 16'h0010);
    pulse(3'b000, 2'b00, 2'b01);
    chk("R6 ext0 re-presented", irq, 1);
    chk("R6 src ext0", src, 5);
    nest = 1'b0; #1;
    chk("R6 blocked without nesting", irq, 0);
    nest = 1'b1;
    pulse(3'b001, 2'b00, 2'b00);
    chk("R6 timer0 first", src, 0);
    do_ack();
    pulse(3'b010, 2'b00, 2'b00);
    chk("R6 timer stays blocked", src, 5);
  endtask

  task automatic t_priority();
    do_reset();
    pulse(3'b000, 2'b11, 2'b11);
    chk("R7 dma0 first", src, 3);
    do_ack(); chk("R7 dma1 next", src, 4);
    do_ack(); chk("R7 ext0 next", src, 5);
    do_ack(); chk("R7 ext1 next", src, 6);
    do_ack(); chk("R7 none left", irq, 0);
    do_reset();
    pulse(3'b110, 2'b01, 2'b00);
    chk("R7 timer1 over timer2 and dma", src, 1);
  endtask

  task automatic t_summary();
    logic [15:0] v;
    do_reset();
    pulse(3'b100, 2'b00, 2'b00);
    rd(3, v); chk("R8 summary timer2", v, 16'h0001);
    do_reset();
    pulse(3'b000, 2'b01, 2'b10);
    rd(3, v); chk("R8 summary no timer", v, 0);
  endtask

  task automatic t_ack_req();
    logic [15:0] v;
    do_reset();
    pulse(3'b000, 2'b01, 2'b00);
    cyc(3'b000, 2'b01, 2'b00, 1'b1, 1'b0, 2'd0, 16'h0);
    rd(0, v); chk("R9 still pending", v, 16'h0004);
    rd(1, v); chk("R9 in service", v, 16'h0004);
    chk("R9 irq blocked", irq, 0);
  endtask

  task automatic t_ack_eoi();
    logic [15:0] v;
    do_reset();
    nest = 1'b1;
    pulse(3'b000, 2'b00, 2'b10);
    do_ack();
    pulse(3'b000, 2'b00, 2'b10);
    chk("R10 ext1 presented", src, 6);
    cyc('0, '0, '0, 1'b1, 1'b1, 2'd2, 16'd13);
    rd(1, v); chk("R10 ack wins", v, 16'h0020);
    wr_reg(2, 16'd13);
    rd(1, v); chk("R10 lone release", v, 0);
  endtask

  task automatic t_ro();
    logic [15:0] v;
    do_reset();
    pulse(3'b001, 2'b00, 2'b00);
    do_ack();
    pulse(3'b000, 2'b10, 2'b00);
    wr_reg(0, 16'hFFFF);
    wr_reg(1, 16'h0000);
    wr_reg(3, 16'hFFFF);
    rd(0, v); chk("R11 request unchanged", v, 16'h0008);
    rd(1, v); chk("R11 in-service unchanged", v, 16'h0001);
    rd(2, v); chk("R11 eoi reads zero", v, 0);
  endtask

  task automatic t_ack_idle();
    logic [15:0] v;
    do_reset();
    do_ack();
    rd(1, v); chk("R12 idle ack", v, 0);
    pulse(3'b001, 2'b00, 2'b00);
    do_ack();
    pulse(3'b010, 2'b00, 2'b00);
    do_ack();
    rd(0, v); chk("R12 blocked ack keeps pending", v, 16'h0010);
    rd(1, v); chk("R12 in-service unchanged", v, 16'h0001);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_req_map();
    t_ack();
    t_eoi();
    t_block();
    t_nest();
    t_priority();
    t_summary();
    t_ack_req();
    t_ack_eoi();
    t_ro();
    t_ack_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule